// File: doc/BRIEF.md
# Cascadable Timer Control Logic

This block holds an 8-bit control register that steers three reloadable down-counters, called timer 3, timer 4 and timer 5. Software writes the register through a plain write port and reads it back at any time. The register sets three things: which timers may count, where timers 3 and 4 take their count ticks from, and whether timers 4 and 5 run as two separate counters or as one counter of twice the width. Each timer raises a one-cycle terminal-count pulse when its count is used up.

A counter takes one of two kinds of count tick. The first is an internal tick: a single-cycle enable produced once every `TICK_DIV` system clocks, which is 8 cycles of a 33 MHz clock and so about 4.125 MHz. The second is the rising edge of an external clock input, taken through a two-flop synchroniser. While a timer's gate bit is low, the timer holds its reload value. In cascade mode, the upper half of the joined counter moves only when the lower half borrows from zero. A test mode drives each terminal-count output from that timer's gate bit, so board wiring can be checked without running the counters.

Top module: `tmr_ctl_top`

## Requirements
- R1: After reset the register reads 0x00, and tc3, tc4 and tc5 are all 0.
- R2: A write stores bits 7 to 1 of the data, and they read back as written from the next cycle. Bit 0 always reads 0 whatever was written to it.
- R3: Bits 7, 6 and 5 are the gates of timers 5, 4 and 3. A timer whose gate is 0 reloads its reload value on every cycle and never pulses.
- R4: A gated single counter with reload value N emits a one-cycle pulse on its tc output once every N+1 count ticks.
- R5: The internal tick is a one-cycle enable every TICK_DIV clocks, which is 8 by default.
- R6: Bit 2 (timer 3) and bit 3 (timer 4) select the count tick: 0 takes the internal tick, 1 takes the rising edges of ext_clk3 or ext_clk4 after synchronisation.
- R7: When timer 5 runs on its own, it always counts the internal tick, whatever bits 3 and 2 hold.
- R8: With bit 4 = 0, timers 4 and 5 form one counter of 2*CNT_W bits with reload value {reload5, reload4}. The counter is gated by bit 6 and clocked as bit 3 selects. It pulses tc4 once every value+1 ticks, and tc5 stays 0.
- R9: With bit 4 = 1, timers 4 and 5 count independently, each under its own gate bit and reload value.
- R10: With bit 1 = 1, tc5, tc4 and tc3 equal gate bits 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register readback |
| ext_clk3 | input | 1 | External clock for timer 3 (asynchronous) |
| ext_clk4 | input | 1 | External clock for timer 4 or the joined counter (asynchronous) |
| reload3 | input | CNT_W | Reload value of timer 3 |
| reload4 | input | CNT_W | Reload value of timer 4, and the lower half in cascade mode |
| reload5 | input | CNT_W | Reload value of timer 5, and the upper half in cascade mode |
| tc3 | output | 1 | Terminal-count pulse of timer 3 |
| tc4 | output | 1 | Terminal-count pulse of timer 4 or of the joined counter |
| tc5 | output | 1 | Terminal-count pulse of timer 5 |

## Verification
The assertions check these properties on every cycle:
- every write returns through readback with bit 0 cleared;
- a closed gate loads the reload value;
- the internal tick, the synchronised edges and the terminal-count pulses never last two cycles in a row;
- in cascade mode the upper half changes only when the lower half stood at zero.

The actual pulse periods need the bench's scenarios. These cover the internal and external tick sources, the independent and joined pairings, the pinning of timer 5 to the internal tick, and the gate-driven outputs of test mode.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;

    localparam int CTL_W = 8;

    // Packed MSB first: gate5 is bit 7 and rsvd is bit 0
    typedef struct packed {
        logic gate5;
        logic gate4;
        logic gate3;
        logic split;     // 1: timers 4/5 independent, 0: joined
        logic sel4_ext;  // 1: ext_clk4 edges, 0: internal tick
        logic sel3_ext;  // 1: ext_clk3 edges, 0: internal tick
        logic test;      // outputs follow gate bits
        logic rsvd;
    } tmr_ctl_t;

    function automatic tmr_ctl_t ctl_from_bus(logic [CTL_W-1:0] d);
        tmr_ctl_t c;
        c      = tmr_ctl_t'(d);
        c.rsvd = 1'b0;
        return c;
    endfunction

    function automatic logic pick_step(logic use_ext, logic tick, logic ext_edge);
        return use_ext ? ext_edge : tick;
    endfunction

endpackage

// File: rtl/tmr_ctl_reg.sv
module tmr_ctl_reg
    import tmr_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output tmr_ctl_t         ctl,
    output logic [CTL_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (wr_en)
            ctl <= ctl_from_bus(wr_data);
    end

    assign rd_data = ctl;

    // R2
    wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == {$past(wr_data[CTL_W-1:1]), 1'b0}));
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int TICK_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TW-1:0] div_cnt;

    assign tick = (div_cnt == TW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else
            sh <= {sh[1:0], async_in};
    end

    assign rise = sh[1] & ~sh[2];

    // R6
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/tmr_cnt_slice.sv
module tmr_cnt_slice #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] rv,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= rv;
        else if (step)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/tmr_ctl_top.sv
module tmr_ctl_top
    import tmr_ctl_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] rd_data,
    input  logic             ext_clk3,
    input  logic             ext_clk4,
    input  logic [CNT_W-1:0] reload3,
    input  logic [CNT_W-1:0] reload4,
    input  logic [CNT_W-1:0] reload5,
    output logic             tc3,
    output logic             tc4,
    output logic             tc5
);
    localparam int N_EXT = 2;

    tmr_ctl_t         ctl;
    logic             tick;
    logic [N_EXT-1:0] ext_raw;
    logic [N_EXT-1:0] ext_rise;
    logic             step3, step4, step5, src4;
    logic             ld3, ld4, ld5;
    logic             zero3, zero4, zero5, pair_zero;
    logic [CNT_W-1:0] cnt3, cnt4, cnt5;
    logic             tc3_q, tc4_q, tc5_q;

    tmr_ctl_reg u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ctl(ctl), .rd_data(rd_data)
    );

    tmr_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst(rst), .tick(tick)
    );

    assign ext_raw = {ext_clk4, ext_clk3};

    for (genvar g = 0; g < N_EXT; g++) begin : g_sync
        tmr_edge_sync u_sync (
            .clk(clk), .rst(rst), .async_in(ext_raw[g]), .rise(ext_rise[g])
        );
    end

    assign step3     = pick_step(ctl.sel3_ext, tick, ext_rise[0]);
    assign src4      = pick_step(ctl.sel4_ext, tick, ext_rise[1]);
    assign pair_zero = zero4 & zero5;

    always_comb begin
        ld3 = !ctl.gate3 || (step3 && zero3);
        if (ctl.split) begin
            ld4   = !ctl.gate4 || (src4 && zero4);
            step4 = src4;
            ld5   = !ctl.gate5 || (tick && zero5);
            step5 = tick;
        end else begin
            ld4   = !ctl.gate4 || (src4 && pair_zero);
            ld5   = ld4;
            step4 = src4;
            step5 = src4 && zero4;
        end
    end

    tmr_cnt_slice #(.W(CNT_W)) u_c3 (
        .clk(clk), .rst(rst), .load(ld3), .step(step3), .rv(reload3),
        .cnt(cnt3), .zero(zero3)
    );
    tmr_cnt_slice #(.W(CNT_W)) u_c4 (
        .clk(clk), .rst(rst), .load(ld4), .step(step4), .rv(reload4),
        .cnt(cnt4), .zero(zero4)
    );
    tmr_cnt_slice #(.W(CNT_W)) u_c5 (
        .clk(clk), .rst(rst), .load(ld5), .step(step5), .rv(reload5),
        .cnt(cnt5), .zero(zero5)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tc3_q <= 1'b0;
            tc4_q <= 1'b0;
            tc5_q <= 1'b0;
        end else begin
            tc3_q <= ctl.gate3 && step3 && zero3;
            tc4_q <= ctl.gate4 && src4 && (ctl.split ? zero4 : pair_zero);
            tc5_q <= ctl.split && ctl.gate5 && tick && zero5;
        end
    end

    assign tc3 = ctl.test ? ctl.gate3 : tc3_q;
    assign tc4 = ctl.test ? ctl.gate4 : tc4_q;
    assign tc5 = ctl.test ? ctl.gate5 : tc5_q;

    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.gate3 |=> (cnt3 == $past(reload3)));

    // R4
    tc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tc3_q |=> !tc3_q);

    // R8
    cascade_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!ctl.split && ctl.gate4) && (cnt5 != $past(cnt5)))
            |-> ($past(cnt4) == '0));
endmodule

// File: tb/tb_tmr_ctl_top.sv
module tb_tmr_ctl_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [7:0]   wr_data = '0;
    logic [7:0]   rd_data;
    logic         ext3 = 1'b0, ext4 = 1'b0;
    logic [W-1:0] rl3 = '0, rl4 = '0, rl5 = '0;
    logic         tc3, tc4, tc5;

    int hp3 = 3, hp4 = 5;
    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    int exp_q[3][$];
    int last_t[3];
    bit armed[3];
    int pcnt[3];
    string req_tag[3];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always begin repeat (hp3) @(posedge clk); #2 ext3 = ~ext3; end
    always begin repeat (hp4) @(posedge clk); #2 ext4 = ~ext4; end

    tmr_ctl_top #(.CNT_W(W), .TICK_DIV(8)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ext_clk3(ext3), .ext_clk4(ext4),
        .reload3(rl3), .reload4(rl4), .reload5(rl5),
        .tc3(tc3), .tc4(tc4), .tc5(tc5)
    );

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // monitor: pops expected pulse intervals as pulses appear
    always @(negedge clk) begin
        logic [2:0] v;
        v = {tc5, tc4, tc3};
        if (!rst) begin
            for (int i = 0; i < 3; i++) begin
                if (v[i]) begin
                    pcnt[i]++;
                    if (armed[i] && exp_q[i].size() > 0) begin
                        int e;
                        e = exp_q[i].pop_front();
                        chk(req_tag[i], cyc - last_t[i], e);
                    end
                    last_t[i] = cyc;
                    armed[i]  = 1'b1;
                end
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic arm(input int ch, input string r, input int interval, input int n);
        armed[ch]   = 1'b0;
        req_tag[ch] = r;
        for (int k = 0; k < n; k++) exp_q[ch].push_back(interval);
    endtask

    task automatic drain(input int ch, input int lim);
        int k;
        k = 0;
        while (exp_q[ch].size() > 0 && k < lim) begin
            @(posedge clk);
            k++;
        end
        if (exp_q[ch].size() > 0) begin
            chk({req_tag[ch], " missing pulses"}, exp_q[ch].size(), 0);
            exp_q[ch].delete();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 readback", rd_data, 0);
        chk("R1 tc outputs", {tc5, tc4, tc3}, 0);

        // R2 reserved bit and readback
        wr(8'h01);
        chk("R2 reserved bit", rd_data, 8'h00);
        wr(8'hA2);
        chk("R2 readback A2", rd_data, 8'hA2);
        @(negedge clk);
        chk("R10 test gates 5,3", {tc5, tc4, tc3}, 3'b101);
        wr(8'h5B);
        chk("R2 readback 5B", rd_data, 8'h5A);
        @(negedge clk);
        chk("R10 test gate 4", {tc5, tc4, tc3}, 3'b010);
        wr(8'h00);

        // R5 internal tick period via reload 0
        rl3 = 8'd0;
        arm(0, "R5 tick period", 8, 3);
        wr(8'h20);
        drain(0, 400);
        wr(8'h00);

        // R4 single counter period
        rl3 = 8'd3;
        arm(0, "R4 timer3 period", 32, 3);
        wr(8'h20);
        drain(0, 400);
        wr(8'h00);

        // R6 external clock on timer 3 (rising every 6 cycles)
        rl3 = 8'd4; hp3 = 3;
        arm(0, "R6 timer3 external", 30, 3);
        wr(8'h24);
        drain(0, 400);
        wr(8'h00);

        // R9 / R7 split mode, timer4 external, timer5 internal
        rl4 = 8'd2; hp4 = 5; rl5 = 8'd5;
        arm(1, "R9 timer4 split", 30, 3);
        arm(2, "R7 timer5 internal", 48, 3);
        wr(8'hD8);
        drain(1, 600);
        drain(2, 600);
        wr(8'h00);

        // R3 gate 3 closed while 4 and 5 run
        rl3 = 8'd0; rl4 = 8'd0; rl5 = 8'd0;
        wr(8'hD0);
        pcnt[0] = 0; pcnt[1] = 0;
        repeat (100) @(posedge clk);
        chk("R3 closed gate no pulses", pcnt[0], 0);
        chk("R3 open gate pulses", int'(pcnt[1] >= 12), 1);
        wr(8'h00);

        // R8 cascade, internal tick: value 0x0105
        rl4 = 8'd5; rl5 = 8'd1;
        pcnt[2] = 0;
        arm(1, "R8 cascade internal", 2096, 2);
        wr(8'h40);
        drain(1, 8000);
        chk("R8 tc5 quiet", pcnt[2], 0);
        wr(8'h00);

        // R8 cascade, external clock rising every 4 cycles: value 0x0100
        rl4 = 8'd0; rl5 = 8'd1; hp4 = 2;
        pcnt[2] = 0;
        arm(1, "R8 cascade external", 1028, 2);
        wr(8'h48);
        drain(1, 4000);
        chk("R8 tc5 quiet ext", pcnt[2], 0);
        wr(8'h00);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule